// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral supervises software by watching an external 64-bit free-running system counter. Software programs an interval (the offset) and starts the watchdog; every refresh arms an absolute deadline equal to the counter value at the refresh plus the offset. If the counter reaches that deadline without a refresh, the block raises its first-stage interrupt and arms a second deadline of the same length. If that one also passes unserviced, it raises a second-stage reset request. Software may treat the first stage as a warning, or it may halve the offset and treat the pair of stages as one long timeout.

Two register frames sit on separate 32-bit buses, each with byte address, write, read and data signals. The refresh frame holds only the refresh register and the identification word. This lets the refresh register be given to a less trusted agent while the control frame stays protected. The control frame holds the enable/status word, the offset and the 64-bit deadline. A parameter chooses version 0, with a 32-bit offset, or version 1, with a 48-bit offset split over two words. The second-stage status flag is kept on a separate power-on reset. After a reset requested by the watchdog itself, software can therefore still see what caused it.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-on reset, the enable, stage-1 and stage-2 flags, the offset and the deadline are all zero, both outputs are low and both read buses return zero.
- R2: A write of any data to the refresh register (refresh frame, byte address 0x000) loads the deadline with the counter value at that clock edge plus the offset, and clears the stage-1 and stage-2 flags at that same edge.
- R3: The control word at control-frame address 0x000 reads as bit 0 = enable, bit 1 = stage-1 flag, bit 2 = stage-2 flag, other bits zero. A write sets enable from data bit 0 and also refreshes. Writing zero stops the watchdog with both flags clear.
- R4: The offset lives at 0x008 (bits 31:0) and, in version 1, at 0x00C (bits 47:32, taken from data bits 15:0). Bits above 47 read zero, and in version 0 address 0x00C reads zero and ignores writes. A write to either offset word refreshes using the newly written offset.
- R5: While enabled, at a clock edge where the counter is at or past the deadline and the stage-1 flag is clear, the stage-1 flag sets and the deadline reloads to that counter value plus the offset. The interrupt output equals the stage-1 flag.
- R6: While enabled, at a clock edge where the counter is at or past the deadline and the stage-1 flag is already set, the stage-2 flag sets. The reset-request output is the stage-2 flag ANDed with enable. With a counter that advances by one per cycle and offset N ≥ 1, stage 1 appears N edges and stage 2 appears 2N edges after the refresh edge.
- R7: While enable is clear, neither flag changes except through a refresh, and the deadline is not reloaded by the counter.
- R8: The stage-2 flag survives the ordinary reset input and is cleared only by the power-on reset input or by a refresh. The ordinary reset clears enable, so the reset-request output is low after it.
- R9: Address 0xFCC in both frames reads the version number in bits 19:16 and zero elsewhere.
- R10: The deadline reads and writes at 0x010 (bits 31:0) and 0x014 (bits 63:32). A deadline write does not refresh, and the stages then time out against the written value.
- R11: Read data appears on the clock edge that samples the read strobe and is zero in every other cycle. Unmapped addresses, including the refresh register itself, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Ordinary asynchronous active-low reset (spares the stage-2 flag) |
| por_ni | input | 1 | Power-on asynchronous active-low reset (clears everything) |
| sys_cnt_i | input | 64 | Free-running system counter value |
| rf_addr_i | input | 12 | Refresh frame byte address |
| rf_wr_i | input | 1 | Refresh frame write strobe |
| rf_rd_i | input | 1 | Refresh frame read strobe |
| rf_wdata_i | input | 32 | Refresh frame write data (value ignored) |
| rf_rdata_o | output | 32 | Refresh frame read data |
| cf_addr_i | input | 12 | Control frame byte address |
| cf_wr_i | input | 1 | Control frame write strobe |
| cf_rd_i | input | 1 | Control frame read strobe |
| cf_wdata_i | input | 32 | Control frame write data |
| cf_rdata_o | output | 32 | Control frame read data |
| stage1_irq_o | output | 1 | First-stage timeout interrupt |
| stage2_rst_o | output | 1 | Second-stage timeout reset request |

## Verification
Every result in this block is due at a known edge. A write takes effect at the edge that samples it. A stage flag sets at the first edge whose sampled counter is at or past the deadline. Read data is valid just after the edge that samples the read strobe. Both reset inputs take effect two edges after release, because of the synchronizers. The bench drives every input one time unit after a rising edge and records the counter value each edge will sample. It then predicts each flag from arithmetic on those recorded values, counting edges from the refresh edge, and samples outputs and read data just after the edge where each one is due. Offsets from 1 to 12 are swept from a counter start just below a 32-bit boundary, so the deadline adder's carry into the upper word is exercised.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W  = 12;
  localparam int BUS_W   = 32;
  localparam int CNT_W   = 64;
  localparam int VER_LSB = 16;
  localparam int VER_W   = 4;

  // control frame
  localparam logic [ADDR_W-1:0] A_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFF_LO = 12'h008;
  localparam logic [ADDR_W-1:0] A_OFF_HI = 12'h00C;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h010;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h014;
  // both frames
  localparam logic [ADDR_W-1:0] A_IDENT  = 12'hFCC;
  // refresh frame
  localparam logic [ADDR_W-1:0] A_KICK   = 12'h000;

  function automatic int offset_width(input int version);
    return (version == 0) ? 32 : 48;
  endfunction
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_offset_reg.sv
module wdog_offset_reg
  import wdog_pkg::*;
#(
  parameter int OFF_W = 48
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [CNT_W-1:0] off_o,
  output logic [CNT_W-1:0] off_nxt_o
);
  localparam int HI_W = OFF_W - BUS_W;

  logic [OFF_W-1:0] off_q, off_d;
  logic             off_en;

  generate
    if (HI_W > 0) begin : g_wide
      always_comb begin
        off_d = off_q;
        if (wr_lo_i) off_d[BUS_W-1:0]     = wdata_i;
        if (wr_hi_i) off_d[OFF_W-1:BUS_W] = wdata_i[HI_W-1:0];
      end
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = wr_hi_i;
      always_comb begin
        off_d = off_q;
        if (wr_lo_i) off_d = wdata_i[OFF_W-1:0];
      end
    end
  endgenerate

  assign off_en = wr_lo_i | wr_hi_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign off_o     = {{(CNT_W-OFF_W){1'b0}}, off_q};
  assign off_nxt_o = {{(CNT_W-OFF_W){1'b0}}, off_d};
endmodule

// File: rtl/wdog_stage_ctrl.sv
module wdog_stage_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic [CNT_W-1:0] sys_cnt_i,
  input  logic             refresh_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  input  logic             cmp_wr_lo_i,
  input  logic             cmp_wr_hi_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] offset_i,
  output logic             en_o,
  output logic             ws0_o,
  output logic             ws1_o,
  output logic [CNT_W-1:0] cmp_o
);
  logic             en_q, en_d;
  logic             ws0_q, ws0_d;
  logic             ws1_q, ws1_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] reload;
  logic             expired, cmp_wr, cmp_en;

  assign reload  = sys_cnt_i + offset_i;
  assign expired = en_q && (sys_cnt_i >= cmp_q);
  assign cmp_wr  = cmp_wr_lo_i | cmp_wr_hi_i;

  always_comb begin
    en_d   = en_q;
    ws0_d  = ws0_q;
    ws1_d  = ws1_q;
    cmp_d  = cmp_q;
    cmp_en = 1'b0;
    if (en_wr_i) en_d = en_val_i;
    if (refresh_i) begin
      ws0_d  = 1'b0;
      ws1_d  = 1'b0;
      cmp_d  = reload;
      cmp_en = 1'b1;
    end else begin
      if (cmp_wr_lo_i) cmp_d[BUS_W-1:0]     = wdata_i;
      if (cmp_wr_hi_i) cmp_d[CNT_W-1:BUS_W] = wdata_i;
      cmp_en = cmp_wr;
      if (expired) begin
        if (!ws0_q) begin
          ws0_d = 1'b1;
          if (!cmp_wr) begin
            cmp_d  = reload;
            cmp_en = 1'b1;
          end
        end else begin
          ws1_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ws0_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ws0_q <= ws0_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  // stage-2 flag is kept across the ordinary reset
  always_ff @(posedge clk or negedge por_ni) begin
    if (!por_ni) ws1_q <= 1'b0;
    else         ws1_q <= ws1_d;
  end

  assign en_o  = en_q;
  assign ws0_o = ws0_q;
  assign ws1_o = ws1_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int VERSION     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [CNT_W-1:0]  sys_cnt_i,
  input  logic [ADDR_W-1:0] rf_addr_i,
  input  logic              rf_wr_i,
  input  logic              rf_rd_i,
  input  logic [BUS_W-1:0]  rf_wdata_i,
  output logic [BUS_W-1:0]  rf_rdata_o,
  input  logic [ADDR_W-1:0] cf_addr_i,
  input  logic              cf_wr_i,
  input  logic              cf_rd_i,
  input  logic [BUS_W-1:0]  cf_wdata_i,
  output logic [BUS_W-1:0]  cf_rdata_o,
  output logic              stage1_irq_o,
  output logic              stage2_rst_o
);
  localparam int OFF_W  = offset_width(VERSION);
  localparam bit HAS_HI = (OFF_W > BUS_W);
  localparam logic [BUS_W-1:0] ID_WORD =
    BUS_W'(VERSION % (1 << VER_W)) << VER_LSB;

  logic rst_n_s, por_n_s, any_rst_n;
  logic unused_rf_data;

  assign any_rst_n      = rst_ni & por_ni;
  assign unused_rf_data = ^rf_wdata_i;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_rst (
    .clk(clk), .arst_ni(any_rst_n), .rst_no(rst_n_s));
  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk(clk), .arst_ni(por_ni), .rst_no(por_n_s));

  // write decode
  logic ctrl_wr, off_lo_wr, off_hi_wr, cmp_lo_wr, cmp_hi_wr, kick_wr;
  logic refresh_w;

  assign ctrl_wr   = cf_wr_i && (cf_addr_i == A_CTRL);
  assign off_lo_wr = cf_wr_i && (cf_addr_i == A_OFF_LO);
  assign off_hi_wr = cf_wr_i && (cf_addr_i == A_OFF_HI) && HAS_HI;
  assign cmp_lo_wr = cf_wr_i && (cf_addr_i == A_CMP_LO);
  assign cmp_hi_wr = cf_wr_i && (cf_addr_i == A_CMP_HI);
  assign kick_wr   = rf_wr_i && (rf_addr_i == A_KICK);
  assign refresh_w = kick_wr | ctrl_wr | off_lo_wr | off_hi_wr;

  logic [CNT_W-1:0] off_w, off_nxt_w, cmp_w;
  logic             en_w, ws0_w, ws1_w;

  wdog_offset_reg #(.OFF_W(OFF_W)) u_off (
    .clk       (clk),
    .rst_ni    (rst_n_s),
    .wr_lo_i   (off_lo_wr),
    .wr_hi_i   (off_hi_wr),
    .wdata_i   (cf_wdata_i),
    .off_o     (off_w),
    .off_nxt_o (off_nxt_w)
  );

  wdog_stage_ctrl u_stage (
    .clk         (clk),
    .rst_ni      (rst_n_s),
    .por_ni      (por_n_s),
    .sys_cnt_i   (sys_cnt_i),
    .refresh_i   (refresh_w),
    .en_wr_i     (ctrl_wr),
    .en_val_i    (cf_wdata_i[0]),
    .cmp_wr_lo_i (cmp_lo_wr),
    .cmp_wr_hi_i (cmp_hi_wr),
    .wdata_i     (cf_wdata_i),
    .offset_i    (off_nxt_w),
    .en_o        (en_w),
    .ws0_o       (ws0_w),
    .ws1_o       (ws1_w),
    .cmp_o       (cmp_w)
  );

  // read paths
  logic [BUS_W-1:0] cf_mux, rf_mux;

  always_comb begin
    unique case (cf_addr_i)
      A_CTRL:   cf_mux = {{(BUS_W-3){1'b0}}, ws1_w, ws0_w, en_w};
      A_OFF_LO: cf_mux = off_w[BUS_W-1:0];
      A_OFF_HI: cf_mux = off_w[CNT_W-1:BUS_W];
      A_CMP_LO: cf_mux = cmp_w[BUS_W-1:0];
      A_CMP_HI: cf_mux = cmp_w[CNT_W-1:BUS_W];
      A_IDENT:  cf_mux = ID_WORD;
      default:  cf_mux = '0;
    endcase
  end

  assign rf_mux = (rf_addr_i == A_IDENT) ? ID_WORD : '0;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cf_rdata_o <= '0;
      rf_rdata_o <= '0;
    end else begin
      cf_rdata_o <= cf_rd_i ? cf_mux : '0;
      rf_rdata_o <= rf_rd_i ? rf_mux : '0;
    end
  end

  assign stage1_irq_o = ws0_w;
  assign stage2_rst_o = ws1_w & en_w;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
  import wdog_pkg::*;
#(
  parameter int VERSION = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              en,
  input logic              ws0,
  input logic              ws1,
  input logic              refresh,
  input logic [CNT_W-1:0]  sys_cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic [ADDR_W-1:0] cf_addr,
  input logic              cf_rd,
  input logic [BUS_W-1:0]  cf_rdata,
  input logic [ADDR_W-1:0] rf_addr,
  input logic              rf_rd,
  input logic [BUS_W-1:0]  rf_rdata
);
  assert_refresh_clears_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    refresh |=> (!ws0 && !ws1));

  assert_offhi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cf_rd && cf_addr == A_OFF_HI) |=> (cf_rdata[BUS_W-1:16] == '0));

  assert_stage1_set_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (en && !refresh && !ws0 && sys_cnt >= cmp) |=> ws0);

  assert_stage2_set_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (en && !refresh && ws0 && sys_cnt >= cmp) |=> ws1);

  assert_stage_order_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(ws1) |-> ws0);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!en && !refresh) |=> ($stable(ws0) && $stable(ws1)));

  assert_ident_ctl_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cf_rd && cf_addr == A_IDENT) |=> (cf_rdata[VER_LSB+VER_W-1:VER_LSB] == VER_W'(VERSION)));

  assert_ident_rfr_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rf_rd && rf_addr == A_IDENT) |=> (rf_rdata[VER_LSB+VER_W-1:VER_LSB] == VER_W'(VERSION)));

  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!cf_rd && !rf_rd) |=> (cf_rdata == '0 && rf_rdata == '0));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.VERSION(VERSION)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .por_n    (por_n_s),
  .en       (en_w),
  .ws0      (ws0_w),
  .ws1      (ws1_w),
  .refresh  (refresh_w),
  .sys_cnt  (sys_cnt_i),
  .cmp      (cmp_w),
  .cf_addr  (cf_addr_i),
  .cf_rd    (cf_rd_i),
  .cf_rdata (cf_rdata_o),
  .rf_addr  (rf_addr_i),
  .rf_rd    (rf_rd_i),
  .rf_rdata (rf_rdata_o)
);

// File: tb/sim_wdog_two_stage.sv
`timescale 1ns/1ps
module sim_wdog_two_stage;
  localparam logic [11:0] A_CTRL = 12'h000, A_OFF_LO = 12'h008, A_OFF_HI = 12'h00C;
  localparam logic [11:0] A_CMP_LO = 12'h010, A_CMP_HI = 12'h014, A_IDENT = 12'hFCC;
  localparam logic [11:0] A_KICK = 12'h000, A_NONE = 12'h020;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic [63:0] sys_cnt = 64'h0000_0000_FFFF_FF80;
  logic [11:0] rf_addr = '0, cf_addr = '0;
  logic        rf_wr = 1'b0, rf_rd = 1'b0, cf_wr = 1'b0, cf_rd = 1'b0;
  logic [31:0] rf_wdata = '0, cf_wdata = '0;
  logic [31:0] rf_rdata, cf_rdata;
  logic        irq, rreq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] edge_cnt;
  logic [31:0] rd;

  always #4 clk = ~clk;

  wdog_two_stage #(.VERSION(1)) u0 (
    .clk(clk), .rst_ni(rst_ni), .por_ni(por_ni), .sys_cnt_i(sys_cnt),
    .rf_addr_i(rf_addr), .rf_wr_i(rf_wr), .rf_rd_i(rf_rd), .rf_wdata_i(rf_wdata),
    .rf_rdata_o(rf_rdata), .cf_addr_i(cf_addr), .cf_wr_i(cf_wr), .cf_rd_i(cf_rd),
    .cf_wdata_i(cf_wdata), .cf_rdata_o(cf_rdata), .stage1_irq_o(irq), .stage2_rst_o(rreq));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one clock edge; edge_cnt holds the counter value that edge sampled
  task automatic cyc();
    edge_cnt = sys_cnt;
    @(posedge clk);
    #1;
    sys_cnt = sys_cnt + 64'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic cf_write(input logic [11:0] a, input logic [31:0] d);
    cf_addr = a; cf_wdata = d; cf_wr = 1'b1;
    cyc();
    cf_wr = 1'b0;
  endtask

  task automatic cf_read(input logic [11:0] a, output logic [31:0] d);
    cf_addr = a; cf_rd = 1'b1;
    cyc();
    cf_rd = 1'b0;
    d = cf_rdata;
  endtask

  task automatic rf_write(input logic [11:0] a, input logic [31:0] d);
    rf_addr = a; rf_wdata = d; rf_wr = 1'b1;
    cyc();
    rf_wr = 1'b0;
  endtask

  task automatic rf_read(input logic [11:0] a, output logic [31:0] d);
    rf_addr = a; rf_rd = 1'b1;
    cyc();
    rf_rd = 1'b0;
    d = rf_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [63:0] ref_e, dl, v;
    // power-on reset
    idle(3);
    rst_ni = 1'b1; por_ni = 1'b1;
    idle(3);

    // R1 reset state
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "rst req after reset", rreq, 0);
    chk("R1", "cf rdata idle", cf_rdata, 0);
    cf_read(A_CTRL, rd);   chk("R1", "ctrl word", rd, 0);
    cf_read(A_OFF_LO, rd); chk("R1", "offset lo", rd, 0);
    cf_read(A_CMP_LO, rd); chk("R1", "deadline lo", rd, 0);

    // R9 identification in both frames
    cf_read(A_IDENT, rd); chk("R9", "ctl ident", rd, 32'h0001_0000);
    rf_read(A_IDENT, rd); chk("R9", "rfr ident", rd, 32'h0001_0000);

    // R11 unmapped and strobe-less reads
    cf_read(A_NONE, rd); chk("R11", "unmapped ctl read", rd, 0);
    rf_read(A_KICK, rd); chk("R11", "refresh reg read", rd, 0);
    cyc(); chk("R11", "rdata without strobe", cf_rdata, 0);

    // R4 offset widths and refresh with new offset
    cf_write(A_OFF_HI, 32'hFFFF_ABCD);
    cf_read(A_OFF_HI, rd); chk("R4", "offset hi masked", rd, 32'h0000_ABCD);
    cf_write(A_OFF_LO, 32'h1234_5678);
    ref_e = edge_cnt + 64'h0000_ABCD_1234_5678;
    cf_read(A_OFF_LO, rd); chk("R4", "offset lo", rd, 32'h1234_5678);
    cf_read(A_CMP_LO, rd); chk("R4", "refresh with new offset lo", rd, ref_e[31:0]);
    cf_read(A_CMP_HI, rd); chk("R4", "refresh with new offset hi", rd, ref_e[63:32]);
    cf_write(A_OFF_HI, 32'h0);

    // R5/R6 sweep of offsets across a 32-bit counter boundary
    for (int off = 1; off <= 12; off++) begin
      cf_write(A_OFF_LO, off);
      cf_write(A_CTRL, 32'h1);
      for (int j = 1; j <= 2 * off + 2; j++) begin
        cyc();
        chk("R5", $sformatf("stage1 off=%0d edge=%0d", off, j), irq, (j >= off) ? 1 : 0);
        chk("R6", $sformatf("stage2 off=%0d edge=%0d", off, j), rreq, (j >= 2 * off) ? 1 : 0);
      end
      cf_read(A_CTRL, rd); chk("R3", "status all set", rd, 32'h7);
      cf_write(A_CTRL, 32'h0);
      chk("R3", "stop clears stage1", irq, 0);
      chk("R3", "stop clears stage2", rreq, 0);
    end

    // R2 refresh frame write postpones and clears
    cf_write(A_OFF_LO, 32'd8);
    cf_write(A_CTRL, 32'h1);
    idle(4);
    rf_write(A_KICK, 32'hDEAD_BEEF);
    for (int j = 1; j <= 16; j++) begin
      cyc();
      chk("R2", $sformatf("stage1 after kick edge=%0d", j), irq, (j >= 8) ? 1 : 0);
    end
    chk("R2", "stage2 reached", rreq, 1);
    rf_write(A_KICK, 32'h0);
    chk("R2", "kick clears stage1", irq, 0);
    chk("R2", "kick clears stage2", rreq, 0);
    cf_read(A_CTRL, rd); chk("R2", "status after kick", rd, 32'h1);

    // R10 deadline access without refresh
    cf_write(A_OFF_LO, 32'd200);
    dl = edge_cnt + 64'd200;
    cf_read(A_CMP_LO, rd); chk("R10", "deadline lo", rd, dl[31:0]);
    cf_read(A_CMP_HI, rd); chk("R10", "deadline hi", rd, dl[63:32]);
    v = sys_cnt + 64'd6;
    cf_write(A_CMP_HI, v[63:32]);
    cf_write(A_CMP_LO, v[31:0]);
    chk("R10", "no refresh from deadline write", irq, 0);
    for (int j = 0; j < 6; j++) begin
      cyc();
      chk("R10", "stage1 against written deadline", irq, (edge_cnt >= v) ? 1 : 0);
    end
    cf_read(A_CMP_LO, rd); chk("R5", "reload after stage1", rd, v[31:0] + 32'd200);

    // R5 counter jumping past the deadline
    cf_write(A_CTRL, 32'h1);
    cyc(); chk("R5", "before jump", irq, 0);
    sys_cnt = sys_cnt + 64'd1000;
    cyc(); chk("R5", "counter passed deadline", irq, 1);
    dl = edge_cnt + 64'd200;
    cf_read(A_CMP_LO, rd); chk("R5", "reload after jump", rd, dl[31:0]);

    // R7 disabled: nothing advances
    cf_write(A_CTRL, 32'h0);
    cf_write(A_OFF_LO, 32'd1);
    dl = edge_cnt + 64'd1;
    idle(20);
    chk("R7", "stage1 held while disabled", irq, 0);
    cf_read(A_CTRL, rd);   chk("R7", "status while disabled", rd, 0);
    cf_read(A_CMP_LO, rd); chk("R7", "deadline not reloaded", rd, dl[31:0]);

    // R8 stage-2 flag across the ordinary reset
    cf_write(A_OFF_LO, 32'd2);
    cf_write(A_CTRL, 32'h1);
    idle(5);
    chk("R8", "stage2 before reset", rreq, 1);
    rst_ni = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    idle(3);
    chk("R8", "rst req low after reset", rreq, 0);
    chk("R8", "irq low after reset", irq, 0);
    cf_read(A_CTRL, rd); chk("R8", "stage2 kept", rd, 32'h4);
    por_ni = 1'b0; rst_ni = 1'b0;
    idle(3);
    por_ni = 1'b1; rst_ni = 1'b1;
    idle(3);
    cf_read(A_CTRL, rd); chk("R8", "power-on clears stage2", rd, 32'h0);
    cf_read(A_OFF_LO, rd); chk("R1", "offset after power-on", rd, 0);

    summary();
  end
endmodule